// File: doc/BRIEF.md
# Dual-Counter Performance Monitor Unit

This unit counts processor events for profiling. Two 32-bit counters share one control word, and each counter watches one of sixteen event strobes. A counter advances only while the privilege level the core reports is enabled in the control word. Exception level takes precedence over the encoded mode.

Software reaches the unit through a small register port. Two write strobes are provided, one for the control word and one for the packed 64-bit counter pair. A read select returns either register. The usual way to sample every N events is to preload a counter with 0x80000000 minus N. When either counter's top bit becomes set and the interrupt enable is on, a level interrupt is raised. It stays raised until software reloads the counters or clears the enable.

Top module: `perf_mon2`

## Requirements
- R1: After reset the control word reads 0, both counters read 0 and `irq` is low.
- R2: The counter register packs the first counter in bits 31:0 and the second in bits 63:32. A write with `cnt_we` loads both counters at the next clock edge. A read with `rd_sel`=1 returns both.
- R3: Control word fields are:
  - bits 3:0 are the mode enables;
  - bit 4 is the interrupt enable;
  - bits 8:5 select the first counter's event;
  - bits 12:9 select the second counter's event.

  A read with `rd_sel`=0 returns bits 12:0 as written and zero in bits 63:13.
- R4: A counter increments by exactly one on each clock in which its selected strobe `evt[sel]` is high and the current mode is enabled. The two counters advance independently in the same cycle.
- R5: When `exl` is 1, control bit 0 alone decides whether counting is enabled. When `exl` is 0, the `priv` input selects the enable bit:
  - 0 (kernel) uses bit 1;
  - 1 (supervisor) uses bit 2;
  - 2 (user) uses bit 3;
  - 3 never counts.
- R6: `irq` is high exactly while control bit 4 is set and either counter has bit 31 set. It falls in the cycle after the counters are rewritten with bit 31 clear, or after the enable is cleared.
- R7: A counter write in the same cycle as a counted event wins, and that event is lost.
- R8: A counter at 0xFFFFFFFF wraps to 0 on its next counted event.
- R9: With the control word all zero, no event changes either counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| cnt_we | input | 1 | Write strobe for the packed counter pair |
| wdata | input | 64 | Write data |
| rd_sel | input | 1 | Read select: 0 control, 1 counters |
| rdata | output | 64 | Read data (combinational) |
| evt | input | 16 | Event strobes, one per event number |
| exl | input | 1 | Core is at exception level |
| priv | input | 2 | Encoded privilege mode |
| irq | output | 1 | Level overflow interrupt |

## Verification
The hardest state to reach from the ports is a counter crossing into bit 31 set, or past 0xFFFFFFFF. Counting there from zero would take billions of cycles. The bench instead preloads the counters through the register port to one step short of each boundary. It then releases a single selected strobe, so the overflow and the wrap each arrive in a single cycle. The write-versus-event collision is produced by raising `cnt_we` and the selected strobe in the same cycle.

// File: rtl/perf_mon2.sv
module perf_mon2 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic        cnt_we,
  input  logic [63:0] wdata,
  input  logic        rd_sel,
  output logic [63:0] rdata,
  input  logic [15:0] evt,
  input  logic        exl,
  input  logic [1:0]  priv,
  output logic        irq
);
  localparam int CW = 13;
  localparam int NW = 32;

  logic [CW-1:0] ctrl_q;
  logic [NW-1:0] c1_q, c2_q;
  logic          mode_ok;
  logic          inc1, inc2;

  always_comb begin
    if (exl) mode_ok = ctrl_q[0];
    else begin
      case (priv)
        2'd0:    mode_ok = ctrl_q[1];
        2'd1:    mode_ok = ctrl_q[2];
        2'd2:    mode_ok = ctrl_q[3];
        default: mode_ok = 1'b0;
      endcase
    end
  end

  assign inc1 = mode_ok & evt[ctrl_q[8:5]];
  assign inc2 = mode_ok & evt[ctrl_q[12:9]];

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wdata[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c1_q <= '0;
      c2_q <= '0;
    end else if (cnt_we) begin
      c1_q <= wdata[NW-1:0];
      c2_q <= wdata[2*NW-1:NW];
    end else begin
      c1_q <= c1_q + NW'(inc1);
      c2_q <= c2_q + NW'(inc2);
    end
  end

  assign rdata = rd_sel ? {c2_q, c1_q} : {{(64-CW){1'b0}}, ctrl_q};
  assign irq   = ctrl_q[4] & (c1_q[NW-1] | c2_q[NW-1]);

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> {c2_q, c1_q} == $past(wdata)); // R7

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> ((c1_q - $past(c1_q)) <= 32'd1) && ((c2_q - $past(c2_q)) <= 32'd1)); // R4

  AST_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && ctrl_q[3:0] == 4'd0) |=> $stable(c1_q) && $stable(c2_q)); // R9

  AST_RESERVED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && !exl && priv == 2'd3) |=> $stable(c1_q) && $stable(c2_q)); // R5

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !wdata[4]) |=> !irq); // R6

  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we && !wdata[31] && !wdata[63]) |=> !irq); // R6
endmodule

// File: tb/test_perf_mon2.sv
module test_perf_mon2;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0, cnt_we = 1'b0, rd_sel = 1'b0, exl = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [15:0] evt = '0;
  logic [1:0]  priv = '0;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  perf_mon2 i_perf_mon2 (.clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .cnt_we(cnt_we),
    .wdata(wdata), .rd_sel(rd_sel), .rdata(rdata), .evt(evt), .exl(exl),
    .priv(priv), .irq(irq));

  // {ctrl[12:9]=sel2, ctrl[8:5]=sel1, ctrl[4]=ie, ctrl[3:0]=modes, exl, priv, evt, d1, d2}
  localparam logic [33:0] VEC [8] = '{
    {4'd7, 4'd3, 1'b0, 4'b0010, 1'b0, 2'd0, 16'h0088, 1'b1, 1'b1},
    {4'd7, 4'd3, 1'b0, 4'b0010, 1'b0, 2'd2, 16'h0088, 1'b0, 1'b0},
    {4'd3, 4'd3, 1'b0, 4'b1000, 1'b0, 2'd2, 16'h0008, 1'b1, 1'b1},
    {4'd15,4'd0, 1'b0, 4'b0100, 1'b0, 2'd1, 16'h8000, 1'b0, 1'b1},
    {4'd6, 4'd5, 1'b0, 4'b0001, 1'b1, 2'd0, 16'h0060, 1'b1, 1'b1},
    {4'd6, 4'd5, 1'b0, 4'b0010, 1'b1, 2'd0, 16'h0060, 1'b0, 1'b0},
    {4'd1, 4'd0, 1'b0, 4'b1111, 1'b0, 2'd3, 16'hFFFF, 1'b0, 1'b0},
    {4'd1, 4'd0, 1'b0, 4'b0000, 1'b0, 2'd0, 16'hFFFF, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [63:0] d);
    ctrl_we = 1'b1; wdata = d;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [63:0] d);
    cnt_we = 1'b1; wdata = d;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [63:0] v);
    rd_sel = sel; #1; v = rdata;
  endtask

  task automatic pulse(input logic [15:0] e, input int n);
    evt = e;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rd(1'b0, v); check("R1 ctrl", v, 64'd0);
    rd(1'b1, v); check("R1 counters", v, 64'd0);
    check("R1 irq", {63'd0, irq}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      wr_ctrl({51'd0, VEC[i][33:21]});
      wr_cnt(64'd0);
      exl = VEC[i][20]; priv = VEC[i][19:18];
      pulse(VEC[i][17:2], 1);
      rd(1'b1, v);
      check($sformatf("R4/R5/R9 vector %0d", i), v, {31'd0, VEC[i][0], 31'd0, VEC[i][1]});
    end
    exl = 1'b0; priv = 2'd0;

    wr_ctrl({64{1'b1}});
    rd(1'b0, v); check("R3 ctrl readback", v, 64'h1FFF);

    wr_ctrl({51'd0, 4'd2, 4'd2, 1'b0, 4'b1111});
    wr_cnt(64'h0000_0005_0000_0009);
    rd(1'b1, v); check("R2 packing", v, 64'h0000_0005_0000_0009);

    wr_cnt(64'd0);
    pulse(16'h0004, 5);
    rd(1'b1, v); check("R4 five cycles both", v, 64'h0000_0005_0000_0005);

    evt = 16'h0004; cnt_we = 1'b1; wdata = 64'h0000_0064_0000_0064;
    @(negedge clk);
    cnt_we = 1'b0; evt = '0;
    rd(1'b1, v); check("R7 write wins", v, 64'h0000_0064_0000_0064);

    wr_ctrl({51'd0, 4'd1, 4'd0, 1'b1, 4'b1111});
    wr_cnt({32'd0, 32'hFFFF_FFFF});
    check("R6 irq on bit31", {63'd0, irq}, 64'd1);
    pulse(16'h0001, 1);
    rd(1'b1, v); check("R8 wrap", v, 64'd0);
    check("R6 irq after wrap", {63'd0, irq}, 64'd0);

    wr_cnt({32'h7FFF_FFFF, 32'd0});
    check("R6 irq before overflow", {63'd0, irq}, 64'd0);
    pulse(16'h0002, 1);
    rd(1'b1, v); check("R6 overflow value", v, {32'h8000_0000, 32'd0});
    check("R6 irq on overflow", {63'd0, irq}, 64'd1);
    wr_ctrl({51'd0, 4'd1, 4'd0, 1'b0, 4'b1111});
    check("R6 irq masked", {63'd0, irq}, 64'd0);
    wr_ctrl({51'd0, 4'd1, 4'd0, 1'b1, 4'b1111});
    check("R6 irq unmasked", {63'd0, irq}, 64'd1);
    wr_cnt(64'd0);
    check("R6 irq after reload", {63'd0, irq}, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule